// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the software-visible register file of a FIFO-buffered serial port. A simple byte-wide bus (one write or one read strobe per cycle, with a byte address) reaches nine registers placed on 4-byte boundaries. The block holds the line mode, the baud divisor, the control word, the FIFO-control word and the port-pin word, each with its own writable-bit mask. It also keeps a sticky status byte whose flags are raised by hardware events and cleared by software writing zero to them.

It drives two interrupt-related outputs. One is a transmit-interrupt level that follows the transmit-interrupt enable in the control word. The other is a one-cycle receive-interrupt withdraw pulse. Transmit-data writes become a push strobe with the byte. Receive-data reads become a pop strobe and return the byte the datapath presents. A FIFO-control write can request a receive flush. The serializer, the deserializer and the FIFO storage live outside the block.

Top module: `serial_regs`

## Requirements
- R1: After a synchronous reset, the baud register reads 0xFF, control reads 0x20, status reads 0x60 (transmit end and transmit empty set), mode, FIFO control and port pins read 0, and every strobe and the transmit-interrupt level are low.
- R2: Writes are masked per register: mode keeps bits 0x7B, control keeps 0xFA, port pins keep 0xF3, and baud and FIFO control keep all eight bits. Reading offsets 0x00, 0x04, 0x08, 0x18 and 0x20 returns mode, baud, control, FIFO control and port pins.
- R3: Status flags sit at bit 6 (transmit end), bit 5 (transmit empty), bit 4 (break), bit 1 (receive full) and bit 0 (data ready). Other status bits always read 0. A write to offset 0x10 clears each flag whose written bit is 0 and leaves a flag unchanged where the written bit is 1.
- R4: `rx_irq_clr` pulses for one cycle after a status write with bit 1 or bit 0 at 0, or after a control write with bit 6 at 0.
- R5: A control write with bit 5 (transmit enable) at 0 sets the transmit-end flag. `tx_irq` equals control bit 7 at all times.
- R6: A write to offset 0x0C clears the transmit-empty flag, pulses `tx_push` for one cycle and presents the written byte on `tx_byte`.
- R7: A read of offset 0x10 while control bit 5 is 1 returns the status as it stood, and then sets the transmit-end and transmit-empty flags.
- R8: A FIFO-control write (offset 0x18) with bit 1 at 1 pulses `rx_flush` for one cycle and clears status bit 1.
- R9: A read of offset 0x1C returns `rx_level` zero-extended. A read of offset 0x14 returns `rx_byte` and produces exactly one `rx_pop` pulse.
- R10: A read of offset 0x0C, 0x24, any offset beyond 0x20 or any offset not a multiple of 4 returns 0xFF. A write to such an offset, or to 0x14 or 0x1C, changes no register and raises no strobe.
- R11: `ev_break`, `ev_rx_full` and `ev_rx_ready` set status bits 4, 1 and 0. A set in the same cycle as a clearing write wins.
- R12: Read data appears on `bus_rdata` one cycle after the read strobe and holds until the next read. When write and read strobes are both high, the cycle is a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| rx_level | input | CNT_W | Receive FIFO occupancy |
| rx_byte | input | 8 | Byte at the receive FIFO head |
| ev_break | input | 1 | Break detected |
| ev_rx_full | input | 1 | Receive trigger level reached |
| ev_rx_ready | input | 1 | Receive data ready |
| mode_o | output | 8 | Mode register |
| baud_o | output | 8 | Baud divisor register |
| ctrl_o | output | 8 | Control register |
| fifo_ctrl_o | output | 8 | FIFO-control register |
| pins_o | output | 8 | Port-pin register |
| status_o | output | 8 | Sticky status byte |
| tx_irq | output | 1 | Transmit interrupt level |
| rx_irq_clr | output | 1 | Receive interrupt withdraw pulse |
| tx_push | output | 1 | Transmit byte strobe |
| tx_byte | output | 8 | Transmit byte |
| rx_pop | output | 1 | Receive pop strobe |
| rx_flush | output | 1 | Receive flush strobe |

## Verification
The bench targets write-one-keeps status semantics. A design that toggled or set flags on written ones, or cleared unmapped bits, would diverge from the model on the first status write with mixed bits. It also targets an event set colliding with a clearing write: a design where the clear wins would lose a receive event. The side effect of a status read when transmit is enabled is checked on both sides of the read, because a design returning the post-set value would never show cleared transmit flags. Misaligned, hole and read-only offsets are exercised to catch decoders that alias addresses or pop and push on stray accesses.

// File: rtl/serial_regs_pkg.sv
package serial_regs_pkg;
  localparam int DW = 8;

  localparam int IDX_MODE = 0;
  localparam int IDX_BAUD = 1;
  localparam int IDX_CTRL = 2;
  localparam int IDX_TXD  = 3;
  localparam int IDX_STAT = 4;
  localparam int IDX_RXD  = 5;
  localparam int IDX_FCTL = 6;
  localparam int IDX_RCNT = 7;
  localparam int IDX_PINS = 8;

  localparam logic [DW-1:0] MODE_MASK = 8'h7B;
  localparam logic [DW-1:0] CTRL_MASK = 8'hFA;
  localparam logic [DW-1:0] PINS_MASK = 8'hF3;
  localparam logic [DW-1:0] STAT_MASK = 8'h73;

  localparam int ST_TEND = 6;
  localparam int ST_TDE  = 5;
  localparam int ST_BRK  = 4;
  localparam int ST_RXF  = 1;
  localparam int ST_DR   = 0;

  localparam int CT_TXEN = 5;
  localparam int CT_RXIE = 6;
  localparam int CT_TXIE = 7;
  localparam int FC_FLUSH = 1;

  localparam logic [DW-1:0] BAUD_RST = 8'hFF;
  localparam logic [DW-1:0] CTRL_RST = 8'h20;
  localparam logic [DW-1:0] STAT_RST = 8'h60;
  localparam logic [DW-1:0] OPEN_BUS = 8'hFF;

  typedef enum logic [3:0] {
    SEL_MODE, SEL_BAUD, SEL_CTRL, SEL_TXD, SEL_STAT,
    SEL_RXD, SEL_FCTL, SEL_RCNT, SEL_PINS, SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/serial_regs_decode.sv
module serial_regs_decode
  import serial_regs_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  localparam int WW = ADDR_W - 2;

  logic [WW-1:0] word;
  assign word = addr[ADDR_W-1:2];

  always_comb begin
    sel = SEL_NONE;
    if (addr[1:0] == 2'b00) begin
      if      (word == WW'(IDX_MODE)) sel = SEL_MODE;
      else if (word == WW'(IDX_BAUD)) sel = SEL_BAUD;
      else if (word == WW'(IDX_CTRL)) sel = SEL_CTRL;
      else if (word == WW'(IDX_TXD))  sel = SEL_TXD;
      else if (word == WW'(IDX_STAT)) sel = SEL_STAT;
      else if (word == WW'(IDX_RXD))  sel = SEL_RXD;
      else if (word == WW'(IDX_FCTL)) sel = SEL_FCTL;
      else if (word == WW'(IDX_RCNT)) sel = SEL_RCNT;
      else if (word == WW'(IDX_PINS)) sel = SEL_PINS;
    end
  end
endmodule

// File: rtl/serial_regs_cfg.sv
module serial_regs_cfg
  import serial_regs_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  reg_sel_e      sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mode_q,
  output logic [DW-1:0] baud_q,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] fctl_q,
  output logic [DW-1:0] pins_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      baud_q <= BAUD_RST;
      ctrl_q <= CTRL_RST;
      fctl_q <= '0;
      pins_q <= '0;
    end else if (wr) begin
      case (sel)
        SEL_MODE: mode_q <= wdata & MODE_MASK;
        SEL_BAUD: baud_q <= wdata;
        SEL_CTRL: ctrl_q <= wdata & CTRL_MASK;
        SEL_FCTL: fctl_q <= wdata;
        SEL_PINS: pins_q <= wdata & PINS_MASK;
        default: ;
      endcase
    end
  end

  // R2
  pins_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr && sel == SEL_PINS) |=> $stable(pins_q));

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr && sel == SEL_MODE) |=> $stable(mode_q));
endmodule

// File: rtl/serial_regs_status.sv
module serial_regs_status
  import serial_regs_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic          rd,
  input  reg_sel_e      sel,
  input  logic [DW-1:0] wdata,
  input  logic          tx_en,
  input  logic          set_brk,
  input  logic          set_rxf,
  input  logic          set_dr,
  output logic [DW-1:0] stat_q
);
  logic [DW-1:0] nxt;

  always_comb begin
    nxt = stat_q;
    if (wr) begin
      case (sel)
        SEL_STAT: nxt = stat_q & (wdata | ~STAT_MASK);
        SEL_CTRL: if (!wdata[CT_TXEN]) nxt[ST_TEND] = 1'b1;
        SEL_TXD:  nxt[ST_TDE] = 1'b0;
        SEL_FCTL: if (wdata[FC_FLUSH]) nxt[ST_RXF] = 1'b0;
        default: ;
      endcase
    end else if (rd && sel == SEL_STAT && tx_en) begin
      nxt[ST_TEND] = 1'b1;
      nxt[ST_TDE]  = 1'b1;
    end
    if (set_brk) nxt[ST_BRK] = 1'b1;
    if (set_rxf) nxt[ST_RXF] = 1'b1;
    if (set_dr)  nxt[ST_DR]  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= STAT_RST;
    else     stat_q <= nxt & STAT_MASK;
  end

  // R6
  tde_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == SEL_TXD) |=> !stat_q[ST_TDE]);

  // R5
  tend_set_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == SEL_CTRL && !wdata[CT_TXEN]) |=> stat_q[ST_TEND]);

  // R3
  tend_w0_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == SEL_STAT && !wdata[ST_TEND]) |=> !stat_q[ST_TEND]);

  // R8
  flush_rxf_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == SEL_FCTL && wdata[FC_FLUSH] && !set_rxf) |=> !stat_q[ST_RXF]);

  // R11
  rxf_set_chk: assert property (@(posedge clk) disable iff (rst)
    set_rxf |=> stat_q[ST_RXF]);

  // R7
  rd_side_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr && rd && sel == SEL_STAT && tx_en) |=> (stat_q[ST_TEND] && stat_q[ST_TDE]));
endmodule

// File: rtl/serial_regs.sv
module serial_regs
  import serial_regs_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [CNT_W-1:0]  rx_level,
  input  logic [7:0]        rx_byte,
  input  logic              ev_break,
  input  logic              ev_rx_full,
  input  logic              ev_rx_ready,
  output logic [7:0]        mode_o,
  output logic [7:0]        baud_o,
  output logic [7:0]        ctrl_o,
  output logic [7:0]        fifo_ctrl_o,
  output logic [7:0]        pins_o,
  output logic [7:0]        status_o,
  output logic              tx_irq,
  output logic              rx_irq_clr,
  output logic              tx_push,
  output logic [7:0]        tx_byte,
  output logic              rx_pop,
  output logic              rx_flush
);
  reg_sel_e      sel;
  logic          rd_only;
  logic [DW-1:0] rd_mux;

  assign rd_only = bus_rd && !bus_wr;

  serial_regs_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  serial_regs_cfg u_cfg (
    .clk    (clk),
    .rst    (rst),
    .wr     (bus_wr),
    .sel    (sel),
    .wdata  (bus_wdata),
    .mode_q (mode_o),
    .baud_q (baud_o),
    .ctrl_q (ctrl_o),
    .fctl_q (fifo_ctrl_o),
    .pins_q (pins_o)
  );

  serial_regs_status u_stat (
    .clk     (clk),
    .rst     (rst),
    .wr      (bus_wr),
    .rd      (rd_only),
    .sel     (sel),
    .wdata   (bus_wdata),
    .tx_en   (ctrl_o[CT_TXEN]),
    .set_brk (ev_break),
    .set_rxf (ev_rx_full),
    .set_dr  (ev_rx_ready),
    .stat_q  (status_o)
  );

  always_comb begin
    case (sel)
      SEL_MODE: rd_mux = mode_o;
      SEL_BAUD: rd_mux = baud_o;
      SEL_CTRL: rd_mux = ctrl_o;
      SEL_STAT: rd_mux = status_o;
      SEL_RXD:  rd_mux = rx_byte;
      SEL_FCTL: rd_mux = fifo_ctrl_o;
      SEL_RCNT: rd_mux = DW'(rx_level);
      SEL_PINS: rd_mux = pins_o;
      default:  rd_mux = OPEN_BUS;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      tx_irq     <= 1'b0;
      rx_irq_clr <= 1'b0;
      tx_push    <= 1'b0;
      tx_byte    <= '0;
      rx_pop     <= 1'b0;
      rx_flush   <= 1'b0;
    end else begin
      if (rd_only) bus_rdata <= rd_mux;
      if (bus_wr && sel == SEL_CTRL) tx_irq <= bus_wdata[CT_TXIE];
      rx_irq_clr <= bus_wr &&
                    ((sel == SEL_STAT && !(bus_wdata[ST_RXF] && bus_wdata[ST_DR])) ||
                     (sel == SEL_CTRL && !bus_wdata[CT_RXIE]));
      tx_push <= bus_wr && sel == SEL_TXD;
      if (bus_wr && sel == SEL_TXD) tx_byte <= bus_wdata;
      rx_pop   <= rd_only && sel == SEL_RXD;
      rx_flush <= bus_wr && sel == SEL_FCTL && bus_wdata[FC_FLUSH];
    end
  end

  // R5
  tx_irq_track_chk: assert property (@(posedge clk) disable iff (rst)
    tx_irq == ctrl_o[CT_TXIE]);

  // R4
  irq_clr_src_chk: assert property (@(posedge clk) disable iff (rst)
    rx_irq_clr |-> $past(bus_wr));

  // R9
  pop_src_chk: assert property (@(posedge clk) disable iff (rst)
    rx_pop |-> $past(bus_rd && !bus_wr));

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tx_push, rx_pop, rx_flush}));

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_only |=> $stable(bus_rdata));
endmodule

// File: tb/tb_serial_regs.sv
module tb_serial_regs;
  localparam int ADDR_W = 6;
  localparam int DEPTH  = 16;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr = 1'b0, rd = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [CNT_W-1:0] level = '0;
  logic [7:0] rxb = '0;
  logic e_brk = 1'b0, e_rxf = 1'b0, e_dr = 1'b0;
  logic [7:0] mode, baud, ctrl, fctl, pins, stat, txb;
  logic txirq, irqclr, push, pop, flush;

  int checks = 0;
  int errors = 0;
  bit run_cmp = 1'b0;

  always #10 clk = ~clk;

  serial_regs #(.ADDR_W(ADDR_W), .FIFO_DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .rx_level(level), .rx_byte(rxb),
    .ev_break(e_brk), .ev_rx_full(e_rxf), .ev_rx_ready(e_dr),
    .mode_o(mode), .baud_o(baud), .ctrl_o(ctrl), .fifo_ctrl_o(fctl),
    .pins_o(pins), .status_o(stat), .tx_irq(txirq), .rx_irq_clr(irqclr),
    .tx_push(push), .tx_byte(txb), .rx_pop(pop), .rx_flush(flush)
  );

  // behavioural reference model
  int m_mode, m_baud, m_ctrl, m_fctl, m_pins, m_stat, m_rdata, m_txb;
  bit m_txirq, m_clr, m_push, m_pop, m_flush;

  function automatic int model_read(int a);
    if (a == 'h00) return m_mode;
    if (a == 'h04) return m_baud;
    if (a == 'h08) return m_ctrl;
    if (a == 'h10) return m_stat;
    if (a == 'h14) return int'(rxb);
    if (a == 'h18) return m_fctl;
    if (a == 'h1C) return int'(level);
    if (a == 'h20) return m_pins;
    return 'hFF;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_baud = 'hFF; m_ctrl = 'h20; m_fctl = 0; m_pins = 0;
      m_stat = 'h60; m_rdata = 0; m_txb = 0;
      m_txirq = 0; m_clr = 0; m_push = 0; m_pop = 0; m_flush = 0;
    end else begin
      int a, d, s;
      a = int'(addr); d = int'(wdata); s = m_stat;
      m_clr = 0; m_push = 0; m_pop = 0; m_flush = 0;
      if (wr) begin
        if (a == 'h00) m_mode = d & 'h7B;
        else if (a == 'h04) m_baud = d;
        else if (a == 'h08) begin
          m_ctrl = d & 'hFA; m_txirq = d[7];
          if (!d[5]) s = s | 'h40;
          if (!d[6]) m_clr = 1;
        end else if (a == 'h0C) begin
          s = s & ~'h20; m_push = 1; m_txb = d;
        end else if (a == 'h10) begin
          for (int b = 0; b < 8; b++) if (!d[b]) s = s & ~(1 << b);
          if (!d[1] || !d[0]) m_clr = 1;
        end else if (a == 'h18) begin
          m_fctl = d;
          if (d[1]) begin m_flush = 1; s = s & ~'h02; end
        end else if (a == 'h20) m_pins = d & 'hF3;
      end else if (rd) begin
        m_rdata = model_read(a);
        if (a == 'h10 && m_ctrl[5]) s = s | 'h60;
        if (a == 'h14) m_pop = 1;
      end
      if (e_brk) s = s | 'h10;
      if (e_rxf) s = s | 'h02;
      if (e_dr)  s = s | 'h01;
      m_stat = s & 'h73;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (run_cmp) begin
      chk("R2 mode", mode, m_mode);
      chk("R2 baud", baud, m_baud);
      chk("R2 ctrl", ctrl, m_ctrl);
      chk("R2 fifo ctrl", fctl, m_fctl);
      chk("R2 pins", pins, m_pins);
      chk("R3 status", stat, m_stat);
      chk("R5 tx_irq", txirq, m_txirq);
      chk("R4 rx_irq_clr", irqclr, m_clr);
      chk("R6 tx_push", push, m_push);
      chk("R6 tx_byte", txb, m_txb);
      chk("R9 rx_pop", pop, m_pop);
      chk("R8 rx_flush", flush, m_flush);
      chk("R12 rdata", rdata, m_rdata);
    end
  end

  task automatic op(bit w, bit r, int a, int d);
    @(posedge clk); #2;
    wr = w; rd = r; addr = ADDR_W'(a); wdata = 8'(d);
  endtask

  task automatic idle();
    op(0, 0, 0, 0);
    e_brk = 0; e_rxf = 0; e_dr = 0;
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    // R1 reset state
    @(negedge clk);
    chk("R1 baud", baud, 'hFF);
    chk("R1 ctrl", ctrl, 'h20);
    chk("R1 status", stat, 'h60);
    chk("R1 mode", mode, 0);
    chk("R1 strobes", {push, pop, flush, irqclr, txirq}, 0);
    run_cmp = 1'b1;

    // R2 masks
    op(1, 0, 'h00, 'hFF); op(1, 0, 'h20, 'hFF); op(1, 0, 'h04, 'h5A);
    op(0, 1, 'h00, 0); idle();
    chk("R2 mode read", rdata, 'h7B);
    op(0, 1, 'h20, 0); idle();
    chk("R2 pins read", rdata, 'hF3);

    // R7 status read side effect, ctrl bit5 set
    op(1, 0, 'h10, 'h00); idle();
    chk("R3 cleared", stat, 'h00);
    op(0, 1, 'h10, 0); idle();
    chk("R7 read value", rdata, 'h00);
    chk("R7 flags set", stat, 'h60);

    // R7 negative: tx disabled -> no set; R5 tend set by ctrl write
    op(1, 0, 'h08, 'h80); idle();
    chk("R5 tend", stat[6], 1);
    chk("R5 tx_irq", txirq, 1);
    op(1, 0, 'h10, 'h00); op(0, 1, 'h10, 0); idle();
    chk("R7 disabled", stat, 'h00);

    // R11 set beats clear
    op(1, 0, 'h10, 'h00); e_rxf = 1; idle();
    chk("R11 set wins", stat[1], 1);

    // R9 count and pop
    level = CNT_W'(9); rxb = 'hC3;
    op(0, 1, 'h1C, 0); idle();
    chk("R9 count", rdata, 9);
    op(0, 1, 'h14, 0); idle();
    chk("R9 rxdata", rdata, 'hC3);
    chk("R9 pop", pop, 1);

    // R10 unmapped / misaligned / read-only
    op(0, 1, 'h28, 0); idle();
    chk("R10 hole", rdata, 'hFF);
    op(0, 1, 'h05, 0); idle();
    chk("R10 misaligned", rdata, 'hFF);
    op(1, 0, 'h1C, 'h00); op(1, 0, 'h14, 'h00); op(1, 0, 'h2C, 'h00); idle();
    chk("R10 write ignored", {mode, pins, stat}, {8'h7B, 8'hF3, 8'h02});

    // R8 flush
    op(1, 0, 'h18, 'hC2); idle();
    chk("R8 flush clears rxf", stat[1], 0);

    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      int sel, a;
      sel = $urandom_range(0, 13);
      case (sel)
        10: a = 'h24; 11: a = 'h3C; 12: a = 'h02; 13: a = 'h11;
        default: a = sel * 4;
      endcase
      level = CNT_W'($urandom_range(0, DEPTH));
      rxb = 8'($urandom);
      op($urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1, a, $urandom);
      e_brk = ($urandom_range(0, 7) == 0);
      e_rxf = ($urandom_range(0, 7) == 0);
      e_dr  = ($urandom_range(0, 7) == 0);
    end
    idle(); idle();
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule